// File: doc/BRIEF.md
# Flash-to-Peer Configuration Sequencer

This block pushes configuration held in flash to a neighbouring FPGA over a shared byte link. A command pulse starts it. It then reads bytes from a simple flash read port and wraps them in the same write-command framing that the host uses. The wrapping is a command letter, a four-digit hex address, a four-digit hex length, the raw data bytes and a carriage return. Two reserved addresses mark the two payloads. Address 0000 carries the 512-byte state image, and address FFFF carries the initialization image.

A restore command sends only the state image. An initialize command sends the state image first. It then reads a 16-bit little-endian length from the page-zero header and checks a four-byte signature at the start of the initialization image. The image is sent only when the length is nonzero and the signature matches. While a command runs, `busy` stays high so that the link multiplexer can hold off forwarded host traffic. The one-cycle `done` pulse, which releases the host response, comes only after the final carriage return has been accepted by the link.

Top module: `cfg_push_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `tx_valid` and `fl_rd` are all low.
- R2: A restore command (`cmd_init`=0) emits exactly one frame. The frame is 0x57 ('W'), then the ASCII text "0000", then "0200", then the 512 flash bytes from address 0x0100 upward, then 0x0D. All hex digits are uppercase ASCII, most significant nibble first.
- R3: An initialize command (`cmd_init`=1) emits the R2 frame and then a second frame. The second frame is 'W', "FFFF", the header length as four hex digits, that many flash bytes from 0x1000 upward (signature included), and 0x0D. The header length is read with its low byte at flash 0x0004 and its high byte at 0x0005.
- R4: When the header length is zero, the initialize command emits only the R2 frame.
- R5: When any of the flash bytes 0x1000..0x1003 differs from 3C, A5, 0F, 96 (in that order), no byte of the second frame is emitted.
- R6: `done` is a single-cycle pulse that follows acceptance of the last frame byte. `busy` falls on the same edge that `done` rises.
- R7: `tx_valid` is never high while `busy` is low.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` does not change on the next cycle.
- R9: A `cmd_start` pulse that arrives while `busy` is high has no effect on the byte stream or on `done`.
- R10: `cmd_init` is sampled only in the cycle that `cmd_start` is accepted.
- R11: `fl_rd` is a one-cycle pulse. No further read is issued until `fl_ack` returns the data of the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command pulse |
| cmd_init | input | 1 | 1 = initialize, 0 = restore; sampled with cmd_start |
| fl_rd | output | 1 | Flash read request pulse |
| fl_addr | output | AW | Flash byte address |
| fl_data | input | 8 | Flash read data, valid with fl_ack |
| fl_ack | input | 1 | Flash read data valid |
| tx_valid | output | 1 | Link byte valid |
| tx_byte | output | 8 | Link byte |
| tx_ready | input | 1 | Link accepts byte |
| busy | output | 1 | Transfer in progress; blocks host forwarding |
| done | output | 1 | Transfers complete; host response may go out |

## Verification
The hardest case to reach is the decision taken after the header read: a nonzero length combined with a signature that fails on only its last byte. Reaching it needs the header and image bytes to be set up exactly. The bench flash model therefore computes every byte from its address, and its header and signature bytes are set per command. Directed runs corrupt the first and the last signature byte and set the length to zero. Random runs mix lengths, signature outcomes, flash latency and link backpressure. One run re-pulses `cmd_start` during a transfer to show that the request is dropped.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam logic [7:0] ASCII_CR = 8'h0D;

  typedef enum logic [2:0] {F_IDLE, F_HEAD, F_DATA, F_TAIL, F_FIN} fr_state_t;
  typedef enum logic [1:0] {C_IDLE, C_LEN, C_SIG} chk_state_t;
  typedef enum logic [2:0] {T_IDLE, T_STATE, T_STW, T_CHK, T_INW, T_FIN} top_state_t;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/cps_img_check.sv
module cps_img_check
  import cps_pkg::*;
#(
  parameter int              AW        = 16,
  parameter logic [AW-1:0]   HDR_BASE  = '0,
  parameter int              LEN_OFS   = 4,
  parameter logic [AW-1:0]   INIT_BASE = AW'(16'h1000),
  parameter logic [31:0]     SIG       = 32'h3CA50F96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          rd,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  input  logic          rd_ack,
  output logic          done,
  output logic          ok,
  output logic [15:0]   img_len
);
  chk_state_t st;
  logic [1:0] idx;
  logic       pend;
  logic [7:0] sig_byte;

  always_comb sig_byte = SIG[8*(3-int'(idx)) +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= C_IDLE; idx <= '0; pend <= 1'b0; rd <= 1'b0; rd_addr <= '0;
      done <= 1'b0; ok <= 1'b0; img_len <= '0;
    end else begin
      rd   <= 1'b0;
      done <= 1'b0;
      case (st)
        C_IDLE: if (start) begin
          idx <= '0; pend <= 1'b0; st <= C_LEN;
        end
        C_LEN: begin
          if (!pend) begin
            rd <= 1'b1; pend <= 1'b1;
            rd_addr <= HDR_BASE + AW'(LEN_OFS) + AW'(idx);
          end else if (rd_ack) begin
            pend <= 1'b0;
            if (idx == 2'd0) begin
              img_len[7:0] <= rd_data; idx <= 2'd1;
            end else begin
              img_len[15:8] <= rd_data; idx <= 2'd0;
              if ({rd_data, img_len[7:0]} == 16'h0) begin
                ok <= 1'b0; done <= 1'b1; st <= C_IDLE;
              end else st <= C_SIG;
            end
          end
        end
        C_SIG: begin
          if (!pend) begin
            rd <= 1'b1; pend <= 1'b1;
            rd_addr <= INIT_BASE + AW'(idx);
          end else if (rd_ack) begin
            pend <= 1'b0;
            if (rd_data != sig_byte) begin
              ok <= 1'b0; done <= 1'b1; st <= C_IDLE;
            end else if (idx == 2'd3) begin
              ok <= 1'b1; done <= 1'b1; st <= C_IDLE;
            end else idx <= idx + 2'd1;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst) rd |=> !rd);
  assert_rd_wait_R11: assert property (@(posedge clk) disable iff (rst) (pend && !rd_ack) |=> !rd);
endmodule

// File: rtl/cps_frame_tx.sv
module cps_frame_tx
  import cps_pkg::*;
#(
  parameter int         AW     = 16,
  parameter logic [7:0] LETTER = 8'h57
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [15:0]   addr_fld,
  input  logic [15:0]   len_fld,
  input  logic [AW-1:0] base,
  output logic          rd,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  input  logic          rd_ack,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_ready,
  output logic          done
);
  fr_state_t   st;
  logic [3:0]  hidx;
  logic [31:0] hdr_word;
  logic [15:0] remain;
  logic [AW-1:0] raddr;
  logic        pend;
  logic        slot_free;

  always_comb slot_free = !tx_valid || tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= F_IDLE; hidx <= '0; hdr_word <= '0; remain <= '0; raddr <= '0;
      pend <= 1'b0; rd <= 1'b0; rd_addr <= '0; tx_valid <= 1'b0;
      tx_byte <= '0; done <= 1'b0;
    end else begin
      rd   <= 1'b0;
      done <= 1'b0;
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          hdr_word <= {addr_fld, len_fld};
          remain <= len_fld; raddr <= base; hidx <= '0; pend <= 1'b0;
          st <= F_HEAD;
        end
        F_HEAD: if (slot_free) begin
          tx_valid <= 1'b1;
          if (hidx == 4'd0) tx_byte <= LETTER;
          else begin
            tx_byte  <= hex_ascii(hdr_word[31:28]);
            hdr_word <= {hdr_word[27:0], 4'h0};
          end
          if (hidx == 4'd8) st <= F_DATA;
          hidx <= hidx + 4'd1;
        end
        F_DATA: begin
          if (pend) begin
            if (rd_ack) begin
              tx_byte <= rd_data; tx_valid <= 1'b1; pend <= 1'b0;
              remain <= remain - 16'd1; raddr <= raddr + AW'(1);
            end
          end else if (remain == 16'd0) st <= F_TAIL;
          else if (!tx_valid) begin
            rd <= 1'b1; rd_addr <= raddr; pend <= 1'b1;
          end
        end
        F_TAIL: if (slot_free) begin
          tx_byte <= ASCII_CR; tx_valid <= 1'b1; st <= F_FIN;
        end
        F_FIN: if (tx_valid && tx_ready) begin
          done <= 1'b1; st <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst) rd |=> !rd);
  assert_rd_wait_R11: assert property (@(posedge clk) disable iff (rst) (pend && !rd_ack) |=> !rd);
endmodule

// File: rtl/cfg_push_seq.sv
module cfg_push_seq
  import cps_pkg::*;
#(
  parameter int            AW         = 16,
  parameter logic [AW-1:0] STATE_BASE = AW'(16'h0100),
  parameter int            STATE_LEN  = 512,
  parameter logic [AW-1:0] HDR_BASE   = '0,
  parameter int            LEN_OFS    = 4,
  parameter logic [AW-1:0] INIT_BASE  = AW'(16'h1000),
  parameter logic [31:0]   SIG        = 32'h3CA50F96,
  parameter logic [15:0]   INIT_ADDR  = 16'hFFFF,
  parameter logic [7:0]    LETTER     = 8'h57
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic          cmd_init,
  output logic          fl_rd,
  output logic [AW-1:0] fl_addr,
  input  logic [7:0]    fl_data,
  input  logic          fl_ack,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_ready,
  output logic          busy,
  output logic          done
);
  localparam logic [15:0] STATE_LEN_F = 16'(STATE_LEN);

  top_state_t    st;
  logic          init_mode;
  logic          fs_start, fs_done, fs_rd;
  logic [15:0]   fs_addr, fs_len;
  logic [AW-1:0] fs_base, fs_rd_addr;
  logic          ck_start, ck_done, ck_ok, ck_rd;
  logic [15:0]   ck_len;
  logic [AW-1:0] ck_rd_addr;

  cps_frame_tx #(.AW(AW), .LETTER(LETTER)) u_frame (
    .clk(clk), .rst(rst), .start(fs_start), .addr_fld(fs_addr), .len_fld(fs_len),
    .base(fs_base), .rd(fs_rd), .rd_addr(fs_rd_addr), .rd_data(fl_data),
    .rd_ack(fl_ack), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .done(fs_done)
  );

  cps_img_check #(.AW(AW), .HDR_BASE(HDR_BASE), .LEN_OFS(LEN_OFS),
                  .INIT_BASE(INIT_BASE), .SIG(SIG)) u_check (
    .clk(clk), .rst(rst), .start(ck_start), .rd(ck_rd), .rd_addr(ck_rd_addr),
    .rd_data(fl_data), .rd_ack(fl_ack), .done(ck_done), .ok(ck_ok), .img_len(ck_len)
  );

  always_comb begin
    fl_rd   = fs_rd | ck_rd;
    fl_addr = ck_rd ? ck_rd_addr : fs_rd_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; init_mode <= 1'b0; busy <= 1'b0; done <= 1'b0;
      fs_start <= 1'b0; fs_addr <= '0; fs_len <= '0; fs_base <= '0; ck_start <= 1'b0;
    end else begin
      fs_start <= 1'b0;
      ck_start <= 1'b0;
      done     <= 1'b0;
      case (st)
        T_IDLE: if (cmd_start) begin
          busy <= 1'b1; init_mode <= cmd_init; st <= T_STATE;
        end
        T_STATE: begin
          fs_start <= 1'b1; fs_addr <= 16'h0000; fs_len <= STATE_LEN_F;
          fs_base <= STATE_BASE; st <= T_STW;
        end
        T_STW: if (fs_done) begin
          if (init_mode) begin ck_start <= 1'b1; st <= T_CHK; end
          else st <= T_FIN;
        end
        T_CHK: if (ck_done) begin
          if (ck_ok) begin
            fs_start <= 1'b1; fs_addr <= INIT_ADDR; fs_len <= ck_len;
            fs_base <= INIT_BASE; st <= T_INW;
          end else st <= T_FIN;
        end
        T_INW: if (fs_done) st <= T_FIN;
        T_FIN: begin done <= 1'b1; busy <= 1'b0; st <= T_IDLE; end
        default: st <= T_IDLE;
      endcase
    end
  end

  assert_tx_needs_busy_R7: assert property (@(posedge clk) disable iff (rst) tx_valid |-> busy);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_one_reader_R11: assert property (@(posedge clk) disable iff (rst) $onehot0({fs_rd, ck_rd}));
endmodule

// File: tb/cfg_push_seq_test.sv
module cfg_push_seq_test;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_start = 1'b0, cmd_init = 1'b0;
  logic fl_rd, fl_ack = 1'b0;
  logic [15:0] fl_addr;
  logic [7:0] fl_data = 8'h00, tx_byte;
  logic tx_valid, tx_ready = 1'b1, busy, done;

  cfg_push_seq uut (.clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_init(cmd_init),
    .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_data(fl_data), .fl_ack(fl_ack),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .busy(busy), .done(done));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int done_cnt = 0, rx_at_done = 0;
  int busy_viol = 0, hold_viol = 0, rd_viol = 0;
  bit random_ready = 1'b0;
  logic [15:0] hl = 16'h0;
  logic [7:0] sigb [4];
  byte unsigned rx[$], ex[$];

  function automatic logic [7:0] fmem(input logic [15:0] a);
    if (a == 16'h0004) return hl[7:0];
    if (a == 16'h0005) return hl[15:8];
    if (a >= 16'h1000 && a < 16'h1004) return sigb[a - 16'h1000];
    return 8'((a * 13) ^ (a >> 7) ^ 16'h5A);
  endfunction

  function automatic byte unsigned hexc(input int n);
    return (n < 10) ? byte'(48 + n) : byte'(55 + n);
  endfunction

  task automatic add_frame(input logic [15:0] a, input logic [15:0] n, input logic [15:0] b);
    ex.push_back(8'h57);
    for (int i = 3; i >= 0; i--) ex.push_back(hexc(int'(a[4*i +: 4])));
    for (int i = 3; i >= 0; i--) ex.push_back(hexc(int'(n[4*i +: 4])));
    for (int i = 0; i < int'(n); i++) ex.push_back(fmem(b + 16'(i)));
    ex.push_back(8'h0D);
  endtask

  task automatic check(input bit ok, input string req, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, msg, act, exp);
    end
  endtask

  // flash model: one outstanding read, 1..3 cycle latency
  bit req_seen = 1'b0;
  logic [15:0] req_a, pend_a;
  int lat = 0;
  bit pend = 1'b0;
  always @(negedge clk) if (fl_rd) begin
    if (pend || req_seen) rd_viol++;
    req_seen = 1'b1; req_a = fl_addr;
  end
  always @(posedge clk) begin
    #1;
    fl_ack = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin fl_ack = 1'b1; fl_data = fmem(pend_a); pend = 1'b0; end
    end else if (req_seen) begin
      req_seen = 1'b0; pend_a = req_a; pend = 1'b1; lat = 1 + int'($urandom % 3);
    end
    tx_ready = random_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // link monitor
  bit prev_stall = 1'b0;
  logic [7:0] prev_byte;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (prev_stall && !(tx_valid && tx_byte == prev_byte)) hold_viol++;
      if (tx_valid && !busy) busy_viol++;
      if (done) begin done_cnt++; rx_at_done = rx.size(); end
      if (tx_valid && tx_ready) rx.push_back(tx_byte);
      prev_stall = tx_valid && !tx_ready;
      prev_byte = tx_byte;
    end
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic set_sig(input int bad);
    sigb[0] = 8'h3C; sigb[1] = 8'hA5; sigb[2] = 8'h0F; sigb[3] = 8'h96;
    if (bad >= 0) sigb[bad] = sigb[bad] ^ 8'h01;
  endtask

  task automatic run(input bit init, input logic [15:0] len, input int bad,
                     input bit dup, input string req);
    int d0, mism;
    hl = len; set_sig(bad);
    ex.delete(); rx.delete();
    add_frame(16'h0000, 16'd512, 16'h0100);
    if (init && len != 0 && bad < 0) add_frame(16'hFFFF, len, 16'h1000);
    d0 = done_cnt;
    @(posedge clk); #1; cmd_start = 1'b1; cmd_init = init;
    @(posedge clk); #1; cmd_start = 1'b0; cmd_init = !init;
    if (dup) begin
      repeat (200) @(posedge clk);
      #1; cmd_start = 1'b1; @(posedge clk); #1; cmd_start = 1'b0;
    end
    while (done_cnt == d0) @(posedge clk);
    repeat (40) @(posedge clk);
    mism = 0;
    for (int i = 0; i < ex.size() && i < rx.size(); i++) if (rx[i] != ex[i]) mism++;
    check(rx.size() == ex.size(), req, "stream length", rx.size(), ex.size());
    check(mism == 0, req, "stream bytes mismatched", mism, 0);
    check(done_cnt == d0 + 1, "R6", "done pulses", done_cnt - d0, 1);
    check(rx_at_done == ex.size(), "R6", "bytes before done", rx_at_done, ex.size());
    check(!busy, "R6", "busy after done", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check(!busy && !done && !tx_valid && !fl_rd, "R1", "outputs after reset",
          int'({busy, done, tx_valid, fl_rd}), 0);
    @(posedge clk); #1; rst = 1'b0;
    run(1'b0, 16'd37, -1, 1'b0, "R2");        // restore ignores header, R10
    random_ready = 1'b1;
    run(1'b1, 16'd37, -1, 1'b0, "R3");
    run(1'b1, 16'd0, -1, 1'b0, "R4");
    run(1'b1, 16'd20, 0, 1'b0, "R5");
    run(1'b1, 16'd20, 3, 1'b0, "R5");
    run(1'b1, 16'd1, -1, 1'b0, "R3");
    run(1'b0, 16'd10, -1, 1'b1, "R9");         // re-pulse while busy, R10 opposite level
    run(1'b1, 16'd300, -1, 1'b1, "R9");
    for (int k = 0; k < 4; k++) begin
      bit ini = ($urandom % 2) != 0;
      logic [15:0] l = 16'(1 + ($urandom % 200));
      int b = (($urandom % 4) == 0) ? int'($urandom % 4) : -1;
      run(ini, l, b, 1'b0, "R3");
    end
    check(busy_viol == 0, "R7", "tx_valid without busy", busy_viol, 0);
    check(hold_viol == 0, "R8", "byte dropped or changed under stall", hold_viol, 0);
    check(rd_viol == 0, "R11", "read while another pending", rd_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule